// File: doc/BRIEF.md
# Fractional-Rate Windowed Bitstream Decimator

This block turns the one-bit output of a sigma-delta style converter into multi-bit samples at a rate that need not divide the clock evenly. A phase accumulator advances by a programmable frequency word on every clock. Each carry out of the accumulator closes one output interval. With a word that does not divide the phase range exactly, the intervals hold either the floor or the ceiling of the clock ratio. For example, a word of 2640 gives intervals of 24 or 25 clocks.

Each incoming bit is weighted by a window coefficient. The coefficient is looked up with the upper bits of the phase at the start of that clock. The weight therefore follows the bit's position within the interval and not its clock count. A 1 bit adds its weight to a running sum, and a 0 bit adds nothing. On the clock that wraps the phase, the finished sum is presented with a one-cycle strobe and the sum restarts from zero. Because the weights follow phase, a short interval and a long interval collect nearly the same total weight, so the gain stays almost flat under fractional decimation.

The window lives in a writable table that resets to a triangle. A controller with two states, idle and run, gates the datapath on whether the frequency word is zero. The transition named start goes from idle to run on the first clock with a nonzero word. The transition named halt goes from run to idle on the first clock with a zero word.

Top module: `frac_window_decim`

## Requirements
- R1: While reset is low and at the first sample after release, sample_valid is 0 and sample_out is 0.
- R2: In run, the phase advances by freq_word each clock and an interval ends on the clock whose addition carries out of the 16-bit phase. Valid strobes are therefore spaced by floor or ceiling of 65536/freq_word clocks. For a word below 32768, a strobe is never followed by another strobe on the next cycle.
- R3: The weight used for a clock is the table entry addressed by phase bits [15:8] at the start of that clock. A 1 bit adds that weight and a 0 bit adds zero.
- R4: On a wrap, sample_out takes the sum including the wrapping clock's bit, and sample_valid is high for that one cycle only. The next interval starts from zero. Between strobes, sample_out holds its value.
- R5: After reset, table entry i holds i for i below 128 and 255-i otherwise, a triangle peaking at 127. With freq_word 256 and an all-ones input, one interval sums to 16256.
- R6: A write with tbl_we high stores tbl_wdata at tbl_addr on that clock. Later intervals use the new value.
- R7: With freq_word 0 the block is idle: phase and sum are cleared, no strobes occur, and a partial interval is discarded. The first clock with a nonzero word only arms the run state, and accumulation begins on the following clock from phase 0.
- R8: With the default window, word 2640 and an all-ones input, every output lies within 1% of the largest output, whether the interval held 24 or 25 clocks.
- R9: The sum is wide enough for 64 clocks of weight 255. With all entries at 255 and word 1024, each output equals 16320.
- R10: A bitstream with 1 and 0 alternating gives outputs within 10% of half the all-ones output at the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Converter bitstream, one bit per clock |
| freq_word | input | 16 | Phase increment per clock; 0 idles the block |
| tbl_we | input | 1 | Window table write enable |
| tbl_addr | input | 8 | Window table write address |
| tbl_wdata | input | 8 | Window table write data |
| sample_out | output | 14 | Weighted sum of the last interval |
| sample_valid | output | 1 | One-cycle strobe marking a new sample_out |

## Verification
The bench builds the block with its defaults: a 16-bit phase, a 256-entry table of 8-bit weights and a 14-bit sum sized for 64 clocks per output. Those sizes are what make the test cases possible. A word of 256 steps the table index by exactly one per clock, so a single programmed entry can be probed alone, and the full default triangle sums to a known total. A word of 1024 gives exactly 64 clocks at full weight, which reaches the sum's upper limit. A word of 2640 mixes intervals of 24 and 25 clocks, so gain flatness and the density response can be measured against a scoreboard fed by an independent phase model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fwd_state_e;

    // Triangular default window: ramps up over the first half, down over the second.
    function automatic int tri_weight(input int idx, input int depth);
        return (idx < depth / 2) ? idx : (depth - 1 - idx);
    endfunction

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] freq_word,
    output logic               active
);
    import fwd_pkg::*;

    fwd_state_e state_q, state_d;
    logic       word_zero;

    assign word_zero = (freq_word == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!word_zero) state_d = ST_RUN;   // start
            ST_RUN:  if (word_zero)  state_d = ST_IDLE;  // halt
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == ST_RUN) && !word_zero;
    end

endmodule

// File: rtl/fwd_phase.sv
module fwd_phase #(
    parameter int PHASE_W = 16,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [PHASE_W-1:0] freq_word,
    output logic [IDX_W-1:0]   win_idx,
    output logic               wrap
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W:0]   phase_sum;

    assign phase_sum = {1'b0, phase_q} + {1'b0, freq_word};
    assign wrap      = active && phase_sum[PHASE_W];
    assign win_idx   = phase_q[PHASE_W-1 -: IDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!active) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_sum[PHASE_W-1:0];
        end
    end

endmodule

// File: rtl/fwd_window_tbl.sv
module fwd_window_tbl #(
    parameter int IDX_W  = 8,
    parameter int COEF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COEF_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COEF_W-1:0] rdata
);
    import fwd_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH*COEF_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [COEF_W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= COEF_W'(tri_weight(g, DEPTH));
            end else if (we && (waddr == IDX_W'(g))) begin
                ent_q <= wdata;
            end
        end
        assign flat[g*COEF_W +: COEF_W] = ent_q;
    end

    assign rdata = flat[int'(raddr)*COEF_W +: COEF_W];

endmodule

// File: rtl/fwd_accum.sv
module fwd_accum #(
    parameter int COEF_W = 8,
    parameter int SUM_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              bit_in,
    input  logic [COEF_W-1:0] weight,
    input  logic              wrap,
    output logic [SUM_W-1:0]  sample_out,
    output logic              sample_valid
);
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_sum;

    assign acc_sum = acc_q + (bit_in ? SUM_W'(weight) : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q        <= '0;
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else if (!active) begin
            acc_q        <= '0;
            sample_valid <= 1'b0;
        end else if (wrap) begin
            acc_q        <= '0;
            sample_out   <= acc_sum;
            sample_valid <= 1'b1;
        end else begin
            acc_q        <= acc_sum;
            sample_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_window_decim.sv
module frac_window_decim #(
    parameter int PHASE_W           = 16,
    parameter int IDX_W             = 8,
    parameter int COEF_W            = 8,
    parameter int MAX_CLKS_PER_OUT  = 64
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         bit_in,
    input  logic [PHASE_W-1:0]                           freq_word,
    input  logic                                         tbl_we,
    input  logic [IDX_W-1:0]                             tbl_addr,
    input  logic [COEF_W-1:0]                            tbl_wdata,
    output logic [COEF_W+$clog2(MAX_CLKS_PER_OUT)-1:0]   sample_out,
    output logic                                         sample_valid
);
    localparam int SUM_W = COEF_W + $clog2(MAX_CLKS_PER_OUT);

    logic              active;
    logic              wrap;
    logic [IDX_W-1:0]  win_idx;
    logic [COEF_W-1:0] weight;

    fwd_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .active    (active)
    );

    fwd_phase #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .freq_word (freq_word),
        .win_idx   (win_idx),
        .wrap      (wrap)
    );

    fwd_window_tbl #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (win_idx),
        .rdata (weight)
    );

    fwd_accum #(.COEF_W(COEF_W), .SUM_W(SUM_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .bit_in       (bit_in),
        .weight       (weight),
        .wrap         (wrap),
        .sample_out   (sample_out),
        .sample_valid (sample_valid)
    );

endmodule

// File: rtl/frac_window_decim_checker.sv
module frac_window_decim_checker #(
    parameter int PHASE_W = 16,
    parameter int COEF_W  = 8,
    parameter int SUM_W   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_in,
    input logic [PHASE_W-1:0] freq_word,
    input logic [SUM_W-1:0]   sample_out,
    input logic               sample_valid
);
    localparam logic [PHASE_W-1:0] HALF_WORD = PHASE_W'(1) << (PHASE_W - 1);
    localparam logic [31:0]        MAX_WT    = (32'd1 << COEF_W) - 32'd1;

    // Ones seen since the previous strobe (a superset of the accumulated bits).
    logic [31:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (freq_word == '0) begin
            ones_q <= '0;
        end else begin
            ones_q <= (sample_valid ? 32'd0 : ones_q) + {31'd0, bit_in};
        end
    end

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (32'(sample_out) <= ones_q * MAX_WT)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_word == '0) |=> !sample_valid); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_out)); // R4

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (freq_word != '0) && (freq_word < HALF_WORD) && $stable(freq_word))
        |=> !sample_valid); // R2

endmodule

bind frac_window_decim frac_window_decim_checker #(
    .PHASE_W (PHASE_W),
    .COEF_W  (COEF_W),
    .SUM_W   (SUM_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (bit_in),
    .freq_word    (freq_word),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
);

// File: tb/frac_window_decim_bench.sv
module frac_window_decim_bench;
    localparam int SW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic [15:0]   freq_word = '0;
    logic          tbl_we = 1'b0;
    logic [7:0]    tbl_addr = '0;
    logic [7:0]    tbl_wdata = '0;
    logic [SW-1:0] sample_out;
    logic          sample_valid;

    frac_window_decim u_frac_window_decim (
        .clk (clk), .rst_n (rst_n), .bit_in (bit_in), .freq_word (freq_word),
        .tbl_we (tbl_we), .tbl_addr (tbl_addr), .tbl_wdata (tbl_wdata),
        .sample_out (sample_out), .sample_valid (sample_valid)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    int got_q[$];
    int gap_q[$];
    int m_tbl[256];
    int m_phase = 0;
    int m_acc = 0;
    bit m_run = 1'b0;
    int gap_cnt = 0;
    int mon_e = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one clock of stimulus plus the reference model of that clock.
    task automatic step(input bit b, input int fw);
        @(negedge clk);
        bit_in = b; freq_word = fw[15:0]; tbl_we = 1'b0;
        if (fw == 0) begin
            m_run = 1'b0; m_phase = 0; m_acc = 0;
        end else if (!m_run) begin
            m_run = 1'b1; m_phase = 0; m_acc = 0;
        end else begin
            if (b) m_acc += m_tbl[m_phase >> 8];
            m_phase += fw;
            if (m_phase >= 65536) begin
                m_phase -= 65536;
                exp_q.push_back(m_acc);
                m_acc = 0;
            end
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a[7:0]; tbl_wdata = d[7:0];
        freq_word = '0; bit_in = 1'b0;
        m_tbl[a] = d; m_run = 1'b0; m_phase = 0; m_acc = 0;
    endtask

    task automatic clear_obs();
        got_q.delete(); gap_q.delete();
    endtask

    // Monitor: pops the scoreboard whenever a strobe appears.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            gap_cnt++;
            if (sample_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", int'(sample_out), -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(int'(sample_out) == mon_e, "R3 scoreboard sample", int'(sample_out), mon_e);
                end
                got_q.push_back(int'(sample_out));
                gap_q.push_back(gap_cnt);
                gap_cnt = 0;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int full_ref, mx, mn, bad, seen24, seen25, other, sz;
        for (int i = 0; i < 256; i++) m_tbl[i] = (i < 128) ? i : 255 - i;

        repeat (3) @(negedge clk);
        chk(sample_valid == 1'b0, "R1 valid in reset", int'(sample_valid), 0);
        chk(sample_out == '0, "R1 out in reset", int'(sample_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample_valid == 1'b0, "R1 valid after release", int'(sample_valid), 0);
        chk(sample_out == '0, "R1 out after release", int'(sample_out), 0);

        // R5: one index per clock walks the whole default triangle.
        clear_obs();
        step(1'b1, 256);
        for (int j = 0; j < 256; j++) step(1'b1, 256);
        repeat (3) step(1'b1, 0);
        chk(got_q.size() == 1, "R5 strobe count", got_q.size(), 1);
        if (got_q.size() > 0) chk(got_q[0] == 16256, "R5 triangle sum", got_q[0], 16256);

        // R8 and R2: fractional ratio with all ones.
        clear_obs();
        repeat (600) step(1'b1, 2640);
        repeat (3) step(1'b1, 0);
        mx = 0; mn = 1 << 30; full_ref = 0;
        foreach (got_q[i]) begin
            if (got_q[i] > mx) mx = got_q[i];
            if (got_q[i] < mn) mn = got_q[i];
            full_ref += got_q[i];
        end
        chk(got_q.size() >= 20, "R2 strobe count", got_q.size(), 24);
        if (got_q.size() > 0) full_ref = full_ref / got_q.size();
        chk((mx - mn) * 100 <= mx, "R8 gain spread", mx - mn, mx / 100);
        seen24 = 0; seen25 = 0; other = 0;
        for (int i = 1; i < gap_q.size(); i++) begin
            if (gap_q[i] == 24) seen24++;
            else if (gap_q[i] == 25) seen25++;
            else other++;
        end
        chk(seen24 > 0 && seen25 > 0 && other == 0, "R2 interval lengths 24/25", other, 0);

        // R7: idle with ones on the input produces nothing.
        sz = got_q.size();
        repeat (20) step(1'b1, 0);
        chk(got_q.size() == sz, "R7 idle strobes", got_q.size() - sz, 0);
        // R7: halt mid-interval discards the partial sum (scoreboard confirms restart).
        repeat (10) step(1'b1, 2640);
        repeat (3) step(1'b1, 0);
        chk(got_q.size() == sz, "R7 partial interval discarded", got_q.size() - sz, 0);

        // R10: alternating bits give about half the full-scale output.
        clear_obs();
        for (int j = 0; j < 600; j++) step(j % 2 == 0, 2640);
        repeat (3) step(1'b0, 0);
        bad = 0;
        foreach (got_q[i]) begin
            mx = 2 * got_q[i] - full_ref;
            if (mx < 0) mx = -mx;
            if (mx * 10 > full_ref) bad++;
        end
        chk(got_q.size() >= 20 && bad == 0, "R10 half density outputs", bad, 0);

        // R9 and R6: full-weight table, 64 clocks per output.
        for (int a = 0; a < 256; a++) wr(a, 255);
        clear_obs();
        repeat (200) step(1'b1, 1024);
        repeat (3) step(1'b1, 0);
        bad = 0;
        foreach (got_q[i]) if (got_q[i] != 16320) bad++;
        chk(got_q.size() >= 3 && bad == 0, "R9 full-scale sum 16320", bad, 0);
        bad = 0;
        for (int i = 1; i < gap_q.size(); i++) if (gap_q[i] != 64) bad++;
        chk(bad == 0, "R2 interval length 64", bad, 0);

        // R6 and R3: a single programmed entry at index 5.
        for (int a = 0; a < 256; a++) wr(a, (a == 5) ? 77 : 0);
        clear_obs();
        step(1'b1, 256);
        for (int j = 0; j < 256; j++) step(1'b1, 256);
        repeat (3) step(1'b0, 0);
        chk(got_q.size() == 1, "R6 strobe count", got_q.size(), 1);
        if (got_q.size() > 0) chk(got_q[0] == 77, "R6 written entry used", got_q[0], 77);
        clear_obs();
        step(1'b1, 256);
        for (int j = 0; j < 256; j++) step(j != 5, 256);
        repeat (3) step(1'b0, 0);
        if (got_q.size() > 0) chk(got_q[0] == 0, "R3 zero bit adds nothing", got_q[0], 0);
        else chk(1'b0, "R3 missing strobe", 0, 1);

        chk(exp_q.size() == 0, "R4 pending expected samples", exp_q.size(), 0);
        finish_run();
    end

endmodule